// File: doc/BRIEF.md
# Quadrature Mixer with Round-Half-to-Even Output

The block shifts a real-valued sample stream to complex baseband. Each cycle that the sample-valid input is high, it takes one signed sample and one cosine/sine word pair from an external oscillator. It multiplies the sample by each word at full precision, which gives an in-phase (I) product and a quadrature (Q) product. Each product is then reduced to the output width. The reduction rounds to nearest, breaks exact ties toward the even value, and clamps any result that does not fit.

Samples and oscillator words are signed fractions with one sign bit, so every value lies in [-1.0, 1.0). Three widths are parameters: the sample width `DATA_W`, the oscillator width `LO_W` and the output width `OUT_W`. `LO_W` may be wider than the sample, for example 18 bits, to push the mixing images further down. The output is taken from the product bits just below the redundant sign bit, so the output has the same fractional format as the sample. The pipeline has no back-pressure. A result appears a fixed three cycles after its input, together with its own valid flag.

Top module: `quad_mixer`

## Requirements
- R1: With defaults (16-bit sample, 16-bit oscillator, 16-bit output), i_o equals round(sample_i*cos_i / 2^15) and q_o equals round(sample_i*sin_i / 2^15), all values two's complement; a zero sample gives zero on both outputs.
- R2: When the discarded fraction is below one half of an output LSB the result rounds down, and when it is above one half it rounds up (for example a product of 16385 gives 1 and 16383 gives 0).
- R3: When the discarded fraction is exactly one half, the result goes to the adjacent even value, for both signs (products 16384→0, 49152→2, -16384→0, -49152→-2).
- R4: A rounded value above the largest positive output is clamped to 0x7FFF, and one below the most negative output is clamped to 0x8000; -1.0 × -1.0 yields 0x7FFF.
- R5: valid_o is high exactly three rising clock edges after a rising edge that sampled valid_i high, and it carries that input's result.
- R6: While rst_ni is low, valid_o, i_o and q_o are all zero.
- R7: Inputs presented with valid_i low have no effect: while valid_o is low, i_o and q_o keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample and oscillator words are valid this cycle |
| sample_i | input | DATA_W | Signed real input sample |
| cos_i | input | LO_W | Signed oscillator cosine word |
| sin_i | input | LO_W | Signed oscillator sine word |
| valid_o | output | 1 | i_o and q_o carry a new result |
| i_o | output | OUT_W | Rounded in-phase product |
| q_o | output | OUT_W | Rounded quadrature product |

## Verification
Every result is due on the third rising edge after the edge that accepted its input. The driver applies inputs at the falling edge and records the cycle number together with the expected I/Q pair, computed by an independent integer model of the rounding. The monitor compares outputs at falling edges only. It pops one expected item for each cycle that valid_o is high and checks that exactly three cycles have passed since that item was issued. The hold and reset checks look at the ports during stretches in which no result is due.

// File: rtl/quad_mixer_pkg.sv
package quad_mixer_pkg;
  typedef enum logic {LANE_I = 1'b0, LANE_Q = 1'b1} lane_e;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/mix_in_stage.sv
module mix_in_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [LO_W-1:0]   cos_i,
  input  logic signed [LO_W-1:0]   sin_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sample_o,
  output logic signed [LO_W-1:0]   cos_o,
  output logic signed [LO_W-1:0]   sin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      cos_o    <= '0;
      sin_o    <= '0;
    end else begin
      valid_o <= valid_i;
      // load only on valid so idle cycles do not toggle the multipliers
      if (valid_i) begin
        sample_o <= sample_i;
        cos_o    <= cos_i;
        sin_o    <= sin_i;
      end
    end
  end
endmodule

// File: rtl/mix_mul_lane.sv
module mix_mul_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 16,
  localparam int unsigned PW    = DATA_W + LO_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [LO_W-1:0]   b_i,
  output logic signed [PW-1:0]     prod_o
);
  logic signed [PW-1:0] prod_d;

  always_comb prod_d = PW'(a_i) * PW'(b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_o <= '0;
    else if (en_i) prod_o <= prod_d;
  end
endmodule

// File: rtl/mix_round_sat.sv
module mix_round_sat #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned SHIFT = 15,
  parameter int unsigned OUT_W = 16,
  localparam int unsigned KW   = IN_W - SHIFT
) (
  input  logic signed [IN_W-1:0]  prod_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam logic [SHIFT-1:0] HALF = SHIFT'(1) << (SHIFT - 1);
  localparam logic signed [KW:0] MAX_X = (KW+1)'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [KW:0] MIN_X = ~MAX_X;

  logic signed [KW-1:0] kept;
  logic [SHIFT-1:0]     frac;
  logic                 round_up;
  logic signed [KW:0]   sum;

  always_comb begin
    kept     = prod_i[IN_W-1:SHIFT];
    frac     = prod_i[SHIFT-1:0];
    // tie goes up only when the kept part is odd: ends even
    round_up = (frac > HALF) || ((frac == HALF) && kept[0]);
    sum      = {kept[KW-1], kept} + (KW+1)'(round_up);
    if (sum > MAX_X)      res_o = MAX_X[OUT_W-1:0];
    else if (sum < MIN_X) res_o = MIN_X[OUT_W-1:0];
    else                  res_o = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 16,
  parameter int unsigned OUT_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [LO_W-1:0]   cos_i,
  input  logic signed [LO_W-1:0]   sin_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o
);
  import quad_mixer_pkg::*;

  localparam int unsigned PW    = DATA_W + LO_W;
  // drop the redundant sign bit and the low fraction bits
  localparam int unsigned SHIFT = PW - OUT_W - 1;

  logic                     s1_valid;
  logic signed [DATA_W-1:0] s1_sample;
  logic signed [LO_W-1:0]   s1_lo [NUM_LANES];
  logic                     s2_valid;
  logic signed [PW-1:0]     s2_prod [NUM_LANES];
  logic signed [OUT_W-1:0]  s2_res  [NUM_LANES];
  logic signed [OUT_W-1:0]  s3_res  [NUM_LANES];

  mix_in_stage #(.DATA_W(DATA_W), .LO_W(LO_W)) i_in_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sample_i (sample_i),
    .cos_i    (cos_i),
    .sin_i    (sin_i),
    .valid_o  (s1_valid),
    .sample_o (s1_sample),
    .cos_o    (s1_lo[LANE_I]),
    .sin_o    (s1_lo[LANE_Q])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      valid_o  <= s2_valid;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    mix_mul_lane #(.DATA_W(DATA_W), .LO_W(LO_W)) i_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (s1_valid),
      .a_i    (s1_sample),
      .b_i    (s1_lo[l]),
      .prod_o (s2_prod[l])
    );

    mix_round_sat #(.IN_W(PW), .SHIFT(SHIFT), .OUT_W(OUT_W)) i_round (
      .prod_i (s2_prod[l]),
      .res_o  (s2_res[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        s3_res[l] <= '0;
      else if (s2_valid)  s3_res[l] <= s2_res[l];
    end
  end

  assign i_o = s3_res[LANE_I];
  assign q_o = s3_res[LANE_Q];
endmodule

// File: rtl/quad_mixer_chk.sv
module quad_mixer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 16,
  parameter int unsigned OUT_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] sample_i,
  input logic signed [LO_W-1:0]   cos_i,
  input logic signed [LO_W-1:0]   sin_i,
  input logic                     valid_o,
  input logic signed [OUT_W-1:0]  i_o,
  input logic signed [OUT_W-1:0]  q_o
);
  localparam logic signed [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [LO_W-1:0]   L_MIN = {1'b1, {(LO_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0]  O_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  a_r5_valid_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o);
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##3 !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));
  a_r4_sat_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(sample_i, 3) == D_MIN && $past(cos_i, 3) == L_MIN) |-> i_o == O_MAX);
  a_r4_sat_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(sample_i, 3) == D_MIN && $past(sin_i, 3) == L_MIN) |-> q_o == O_MAX);
  a_r1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(sample_i, 3) == '0) |-> (i_o == '0 && q_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) a_r6_reset: assert (!valid_o && i_o == '0 && q_o == '0);
  end
endmodule

bind quad_mixer quad_mixer_chk #(.DATA_W(DATA_W), .LO_W(LO_W), .OUT_W(OUT_W)) i_chk (.*);

// File: tb/test_quad_mixer.sv
`timescale 1ns/1ps
module test_quad_mixer;
  localparam int DATA_W = 16;
  localparam int LO_W   = 16;
  localparam int OUT_W  = 16;
  localparam int SH     = DATA_W + LO_W - OUT_W - 1;

  typedef struct {
    logic signed [OUT_W-1:0] ei;
    logic signed [OUT_W-1:0] eq;
    int                      cyc;
    string                   tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic vin = 0;
  logic signed [DATA_W-1:0] smp = '0;
  logic signed [LO_W-1:0]   cw = '0, sw = '0;
  logic vout;
  logic signed [OUT_W-1:0]  io, qo;

  int n_tests = 0, n_fail = 0, cyc = 0;
  item_t sb[$];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_mixer #(.DATA_W(DATA_W), .LO_W(LO_W), .OUT_W(OUT_W)) i_quad_mixer (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sample_i(smp),
    .cos_i(cw), .sin_i(sw), .valid_o(vout), .i_o(io), .q_o(qo));

  function automatic logic signed [OUT_W-1:0] ref_mix(longint d, longint c);
    longint p, q, f, h, mx, mn;
    p  = d * c;
    q  = p >>> SH;
    f  = p - (q <<< SH);
    h  = longint'(1) <<< (SH - 1);
    if (f > h || (f == h && q[0])) q = q + 1;
    mx = (longint'(1) <<< (OUT_W - 1)) - 1;
    mn = -mx - 1;
    if (q > mx) q = mx;
    if (q < mn) q = mn;
    return OUT_W'(q);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(string tag, int d, int c, int s);
    item_t it;
    @(negedge clk);
    vin = 1; smp = DATA_W'(d); cw = LO_W'(c); sw = LO_W'(s);
    it.ei = ref_mix(longint'(smp), longint'(cw));
    it.eq = ref_mix(longint'(smp), longint'(sw));
    it.cyc = cyc; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    vin = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vin = 0; smp = DATA_W'($urandom); cw = LO_W'($urandom); sw = LO_W'($urandom);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vout) begin
      if (sb.size() == 0) begin
        check("R5 unexpected valid_o", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " I"}, io, it.ei);
        check({it.tag, " Q"}, qo, it.eq);
        check("R5 latency", cyc - it.cyc, 3);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset valid_o", vout, 0);
    check("R6 reset i_o", io, 0);
    check("R6 reset q_o", qo, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R2 rounding away from ties
    send("R2 above half", 1, 16385, 16383);
    send("R2 neg", -1, 16385, 16383);
    // R3 ties to even, both signs
    send("R3 tie pos", 1, 16384, 16384);
    send("R3 tie 1.5", 3, 16384, -16384);
    send("R3 tie neg", -1, 16384, 16384);
    send("R3 tie -1.5", -3, 16384, 16384);
    // R4 full scale
    send("R4 minxmin", -32768, -32768, 32767);
    send("R4 maxxmax", 32767, 32767, -32768);
    send("R4 minxmax", -32768, 32767, -32768);
    // R1 zero sample and general products
    send("R1 zero", 0, 12345, -32768);
    for (int k = 0; k < 200; k++)
      send("R1 random", int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))));
    // back-to-back stream
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      item_t it;
      vin = 1; smp = DATA_W'($urandom); cw = LO_W'($urandom); sw = LO_W'($urandom);
      it.ei = ref_mix(longint'(smp), longint'(cw));
      it.eq = ref_mix(longint'(smp), longint'(sw));
      it.cyc = cyc; it.tag = "R5 stream";
      sb.push_back(it);
      @(negedge clk);
    end
    vin = 0;
    idle(5);
    check("R5 queue drained", sb.size(), 0);

    // R7 inputs with valid low are ignored
    begin
      logic signed [OUT_W-1:0] hi, hq;
      send("R7 ref", 1000, 20000, -20000);
      idle(4);
      hi = io; hq = qo;
      idle(8);
      check("R7 valid_o low", vout, 0);
      check("R7 i_o held", io, hi);
      check("R7 q_o held", qo, hq);
    end

    // R6 reset mid-flight
    send("R6 inflight", 30000, 30000, 30000);
    rst_n = 0;
    sb.delete();
    @(negedge clk);
    check("R6 mid valid_o", vout, 0);
    check("R6 mid i_o", io, 0);
    check("R6 mid q_o", qo, 0);
    rst_n = 1;
    idle(5);
    check("R6 no stale output", vout, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule